// File: doc/BRIEF.md
# Event-Triggered Block Transfer Engine

The engine serves 24 channels. Each channel owns a descriptor holding a mode byte, a source address, a destination address, a block size and a transfer count. A one-cycle pulse on a channel's request line latches an activation for that channel. When the engine is idle it takes the lowest-numbered pending channel and copies one block of bytes over a single-port memory bus. Each byte uses one read cycle followed by one write cycle. After the block it writes the updated addresses and count back into the descriptor. It can then continue with the next-numbered channel's descriptor in the same activation, and it pulses a per-channel interrupt when a count runs out.

In repeat mode one side, source or destination, is the repeat area. That side always steps through memory. When the count expires, both that side's address and the count return to the values software last wrote. Software programs descriptors through a simple write port, one field per write, and sets each channel's enable bit to arm it.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: After reset, busy, bus_rd, bus_wr and every irq bit are low, and no channel is enabled.
- R2: Each byte is one cycle with bus_rd high at the source address, then one cycle with bus_wr high at the destination address, carrying the byte read. The two strobes are never high together.
- R3: A size field value N of 1..255 moves N bytes per activation, and a value of 0 moves 256 bytes.
- R4: Mode bit 2 set makes the source step up by one per byte, and clear keeps it fixed. Mode bit 3 does the same for the destination. The stepped address is kept in the descriptor for the next activation. Config field codes are: 0 mode, 1 source (also saved as its start), 2 destination (also saved as its start), 3 size, 4 count (also saved as its reload value), 5 enable (data bit 0).
- R5: Each activation decrements the count by one. In normal mode (mode bit 0 clear), the activation that takes the count from 1 to 0 pulses irq for that channel for one cycle and clears its enable. Requests to a disabled channel cause no bus activity until software re-enables it.
- R6: With mode bit 0 set, mode bit 1 clear makes the destination the repeat area and set makes the source the repeat area. The repeat side steps up regardless of its bit 2/3 setting. At expiry the count and the repeat-side address reload from their saved values, the enable stays set, and irq pulses only when mode bit 5 is set.
- R7: With mode bit 4 set, the next channel's descriptor runs in the same activation. Channel 23 never chains further, even if its bit 4 is set.
- R8: Several pending activations are served one at a time, lowest channel number first.
- R9: busy rises the cycle after an activation is accepted and stays high through every byte of every chained descriptor. No bus strobe occurs while busy is low.
- R10: A count field of 0 means 256 activations before expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_ch | input | 5 | Channel being written |
| cfg_field | input | 3 | Field code (see R4) |
| cfg_wdata | input | 16 | Field value |
| act_req | input | 24 | Per-channel activation pulses |
| bus_addr | output | 16 | Memory address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| busy | output | 1 | Transfer in progress |
| irq | output | 24 | Per-channel interrupt pulses |

## Verification
Two situations are the hardest to reach from the ports. One is the 256th activation of a channel whose count was written as zero. The other is a repeat-area reload that happens only after several activations. The stimulus fires the same channel repeatedly in directed loops until the count expires, and each following activation is compared against a bench model, so a wrong reload shows up as wrong bus addresses. Random descriptors over a group of chained channels, fired in random subsets, mix chaining, repeat sides and expiries with the priority order.

// File: rtl/evt_xfer_pkg.sv
// Shared types and field codes for the block transfer engine.
package evt_xfer_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_LOAD = 3'd1,
        S_RD   = 3'd2,
        S_WR   = 3'd3,
        S_UPD  = 3'd4
    } xfer_state_t;

    localparam logic [2:0] F_MODE = 3'd0;
    localparam logic [2:0] F_SRC  = 3'd1;
    localparam logic [2:0] F_DST  = 3'd2;
    localparam logic [2:0] F_SIZE = 3'd3;
    localparam logic [2:0] F_CNT  = 3'd4;
    localparam logic [2:0] F_EN   = 3'd5;

    localparam int MODE_W = 6;
endpackage

// File: rtl/xfer_desc_regs.sv
// Descriptor register file: one set of fields per channel, written by
// software one field at a time and updated by the engine after each block.
// Assumes an engine update has priority over a software write in the same cycle.
module xfer_desc_regs
    import evt_xfer_pkg::*;
#(
    parameter int NCH = 24,
    parameter int AW  = 16,
    parameter int CW  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CW-1:0]       cfg_ch,
    input  logic [2:0]          cfg_field,
    input  logic [AW-1:0]       cfg_wdata,
    input  logic [CW-1:0]       rd_ch,
    input  logic                upd_we,
    input  logic [CW-1:0]       upd_ch,
    input  logic [AW-1:0]       upd_src,
    input  logic [AW-1:0]       upd_dst,
    input  logic [7:0]          upd_cnt,
    input  logic                upd_dis,
    output logic [MODE_W-1:0]   rd_mode,
    output logic [AW-1:0]       rd_src,
    output logic [AW-1:0]       rd_dst,
    output logic [AW-1:0]       rd_src0,
    output logic [AW-1:0]       rd_dst0,
    output logic [7:0]          rd_size,
    output logic [7:0]          rd_cnt,
    output logic [7:0]          rd_cnt0,
    output logic [NCH-1:0]      en
);
    logic [MODE_W-1:0] mode_q [NCH];
    logic [AW-1:0]     src_q  [NCH];
    logic [AW-1:0]     dst_q  [NCH];
    logic [AW-1:0]     src0_q [NCH];
    logic [AW-1:0]     dst0_q [NCH];
    logic [7:0]        size_q [NCH];
    logic [7:0]        cnt_q  [NCH];
    logic [7:0]        cnt0_q [NCH];

    // Field storage: software writes first, engine write-back overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                mode_q[i] <= '0;
                src_q[i]  <= '0;
                dst_q[i]  <= '0;
                src0_q[i] <= '0;
                dst0_q[i] <= '0;
                size_q[i] <= '0;
                cnt_q[i]  <= '0;
                cnt0_q[i] <= '0;
            end
            en <= '0;
        end else begin
            if (cfg_we) begin
                case (cfg_field)
                    F_MODE: mode_q[cfg_ch] <= cfg_wdata[MODE_W-1:0];
                    F_SRC: begin
                        src_q[cfg_ch]  <= cfg_wdata;
                        src0_q[cfg_ch] <= cfg_wdata;
                    end
                    F_DST: begin
                        dst_q[cfg_ch]  <= cfg_wdata;
                        dst0_q[cfg_ch] <= cfg_wdata;
                    end
                    F_SIZE: size_q[cfg_ch] <= cfg_wdata[7:0];
                    F_CNT: begin
                        cnt_q[cfg_ch]  <= cfg_wdata[7:0];
                        cnt0_q[cfg_ch] <= cfg_wdata[7:0];
                    end
                    F_EN: en[cfg_ch] <= cfg_wdata[0];
                    default: ;
                endcase
            end
            if (upd_we) begin
                src_q[upd_ch] <= upd_src;
                dst_q[upd_ch] <= upd_dst;
                cnt_q[upd_ch] <= upd_cnt;
                if (upd_dis) en[upd_ch] <= 1'b0;
            end
        end
    end

    // Combinational read port for the engine.
    always_comb begin
        rd_mode = mode_q[rd_ch];
        rd_src  = src_q[rd_ch];
        rd_dst  = dst_q[rd_ch];
        rd_src0 = src0_q[rd_ch];
        rd_dst0 = dst0_q[rd_ch];
        rd_size = size_q[rd_ch];
        rd_cnt  = cnt_q[rd_ch];
        rd_cnt0 = cnt0_q[rd_ch];
    end

    p_reload_keeps_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_we && !upd_dis && !(cfg_we && cfg_field == F_EN && cfg_ch == upd_ch)
         && en[upd_ch]) |=> en[$past(upd_ch)])
        else $error("p_reload_keeps_en_r6");
endmodule

// File: rtl/xfer_arb.sv
// Activation arbiter: latches request pulses of enabled channels and offers
// the lowest-numbered pending channel. Assumes take is high only when the
// engine is idle and grant_vld is high.
module xfer_arb #(
    parameter int NCH = 24,
    parameter int CW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] en,
    input  logic           take,
    output logic           grant_vld,
    output logic [CW-1:0]  grant_ch
);
    logic [NCH-1:0] pending;
    logic [NCH-1:0] clr_mask;

    // Lowest pending channel wins.
    always_comb begin
        grant_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pending[i]) grant_ch = CW'(i);
        end
        grant_vld = |pending;
        clr_mask  = take ? (NCH'(1) << grant_ch) : '0;
    end

    // Pending set: new enabled requests in, the taken channel out.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_mask) | (req & en);
    end

    p_take_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> grant_vld) else $error("p_take_needs_grant_r8");
    p_one_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take) else $error("p_one_at_a_time_r8");
endmodule

// File: rtl/xfer_engine.sv
// Transfer state machine: loads one descriptor, moves its block byte by byte
// (read cycle then write cycle), writes back addresses and count, handles
// repeat reload, expiry interrupts and chaining to the next channel.
// Assumes bus_rdata is valid in the same cycle as bus_rd.
module xfer_engine
    import evt_xfer_pkg::*;
#(
    parameter int NCH = 24,
    parameter int AW  = 16,
    parameter int CW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_vld,
    input  logic [CW-1:0]     grant_ch,
    output logic              take,
    output logic [CW-1:0]     rd_ch,
    input  logic [MODE_W-1:0] rd_mode,
    input  logic [AW-1:0]     rd_src,
    input  logic [AW-1:0]     rd_dst,
    input  logic [AW-1:0]     rd_src0,
    input  logic [AW-1:0]     rd_dst0,
    input  logic [7:0]        rd_size,
    input  logic [7:0]        rd_cnt,
    input  logic [7:0]        rd_cnt0,
    output logic              upd_we,
    output logic [AW-1:0]     upd_src,
    output logic [AW-1:0]     upd_dst,
    output logic [7:0]        upd_cnt,
    output logic              upd_dis,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              busy,
    output logic [NCH-1:0]    irq
);
    localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

    xfer_state_t       state;
    logic [CW-1:0]     ch;
    logic [MODE_W-1:0] mode;
    logic [AW-1:0]     src, dst;
    logic [8:0]        left;
    logic [7:0]        data;

    logic rep, src_rep, dst_rep, src_step, dst_step, expire, raise, chain;

    // Step and expiry decisions derived from the loaded mode byte.
    always_comb begin
        rep      = mode[0];
        src_rep  = rep & mode[1];
        dst_rep  = rep & ~mode[1];
        src_step = src_rep | mode[2];
        dst_step = dst_rep | mode[3];
        expire   = (rd_cnt == 8'd1);
        raise    = expire & (~rep | mode[5]);
        chain    = mode[4] & (ch != LAST_CH);
    end

    // Descriptor access, write-back values and bus outputs.
    always_comb begin
        take      = (state == S_IDLE) && grant_vld;
        rd_ch     = ch;
        upd_we    = (state == S_UPD);
        upd_src   = (expire && src_rep) ? rd_src0 : src;
        upd_dst   = (expire && dst_rep) ? rd_dst0 : dst;
        upd_cnt   = (expire && rep) ? rd_cnt0 : rd_cnt - 8'd1;
        upd_dis   = expire & ~rep;
        bus_rd    = (state == S_RD);
        bus_wr    = (state == S_WR);
        bus_addr  = (state == S_WR) ? dst : src;
        bus_wdata = data;
        busy      = (state != S_IDLE);
    end

    // Sequencer and working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ch    <= '0;
            mode  <= '0;
            src   <= '0;
            dst   <= '0;
            left  <= '0;
            data  <= '0;
            irq   <= '0;
        end else begin
            irq <= '0;
            case (state)
                S_IDLE: if (grant_vld) begin
                    ch    <= grant_ch;
                    state <= S_LOAD;
                end
                S_LOAD: begin
                    mode  <= rd_mode;
                    src   <= rd_src;
                    dst   <= rd_dst;
                    left  <= {rd_size == 8'd0, rd_size};
                    state <= S_RD;
                end
                S_RD: begin
                    data  <= bus_rdata;
                    state <= S_WR;
                end
                S_WR: begin
                    src   <= src + AW'(src_step);
                    dst   <= dst + AW'(dst_step);
                    left  <= left - 9'd1;
                    state <= (left == 9'd1) ? S_UPD : S_RD;
                end
                S_UPD: begin
                    if (raise) irq[ch] <= 1'b1;
                    if (chain) begin
                        ch    <= ch + CW'(1);
                        state <= S_LOAD;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)) else $error("p_strobe_excl_r2");
    p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd)) else $error("p_write_follows_read_r2");
    p_strobe_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> busy) else $error("p_strobe_in_busy_r9");
    p_irq_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq)) else $error("p_irq_onehot_r5");
    p_last_no_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UPD && ch == LAST_CH) |=> state == S_IDLE)
        else $error("p_last_no_chain_r7");
endmodule

// File: rtl/evt_xfer_ctrl.sv
// Top of the event-triggered block transfer engine: descriptor file,
// activation arbiter and transfer state machine.
// Assumes a single-port memory with same-cycle read data.
module evt_xfer_ctrl
    import evt_xfer_pkg::*;
#(
    parameter  int NCH = 24,
    parameter  int AW  = 16,
    localparam int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CW-1:0]  cfg_ch,
    input  logic [2:0]     cfg_field,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NCH-1:0] act_req,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic [7:0]     bus_wdata,
    input  logic [7:0]     bus_rdata,
    output logic           busy,
    output logic [NCH-1:0] irq
);
    logic              grant_vld, take, upd_we, upd_dis;
    logic [CW-1:0]     grant_ch, rd_ch;
    logic [MODE_W-1:0] rd_mode;
    logic [AW-1:0]     rd_src, rd_dst, rd_src0, rd_dst0, upd_src, upd_dst;
    logic [7:0]        rd_size, rd_cnt, rd_cnt0, upd_cnt;
    logic [NCH-1:0]    en;

    xfer_desc_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .rd_ch(rd_ch),
        .upd_we(upd_we), .upd_ch(rd_ch), .upd_src(upd_src), .upd_dst(upd_dst),
        .upd_cnt(upd_cnt), .upd_dis(upd_dis),
        .rd_mode(rd_mode), .rd_src(rd_src), .rd_dst(rd_dst),
        .rd_src0(rd_src0), .rd_dst0(rd_dst0), .rd_size(rd_size),
        .rd_cnt(rd_cnt), .rd_cnt0(rd_cnt0), .en(en)
    );

    xfer_arb #(.NCH(NCH), .CW(CW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(act_req), .en(en), .take(take),
        .grant_vld(grant_vld), .grant_ch(grant_ch)
    );

    xfer_engine #(.NCH(NCH), .AW(AW), .CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .grant_vld(grant_vld), .grant_ch(grant_ch), .take(take), .rd_ch(rd_ch),
        .rd_mode(rd_mode), .rd_src(rd_src), .rd_dst(rd_dst),
        .rd_src0(rd_src0), .rd_dst0(rd_dst0), .rd_size(rd_size),
        .rd_cnt(rd_cnt), .rd_cnt0(rd_cnt0),
        .upd_we(upd_we), .upd_src(upd_src), .upd_dst(upd_dst),
        .upd_cnt(upd_cnt), .upd_dis(upd_dis),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .irq(irq)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !bus_rd && !bus_wr && irq == '0))
        else $error("p_reset_quiet_r1");
endmodule

// File: tb/tb_evt_xfer_ctrl.sv
module tb_evt_xfer_ctrl;
    localparam int NCH = 24;
    localparam int AW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [4:0]     cfg_ch = '0;
    logic [2:0]     cfg_field = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [NCH-1:0] act_req = '0;
    logic [AW-1:0]  bus_addr;
    logic           bus_rd, bus_wr, busy;
    logic [7:0]     bus_wdata, bus_rdata;
    logic [NCH-1:0] irq;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign bus_rdata = memf(bus_addr);

    evt_xfer_ctrl dut (.*);

    int n_chk = 0, n_bad = 0;
    int strobe_bad = 0;
    int got_n = 0, exp_n = 0;
    logic [AW-1:0] got_a [4096];
    logic [7:0]    got_d [4096];
    logic [AW-1:0] exp_a [4096];
    logic [7:0]    exp_d [4096];
    logic [NCH-1:0] irq_seen = '0, exp_irq = '0;
    logic busy_seen = 1'b0;

    // Bench-side descriptor model.
    logic [7:0]    m_mode [NCH];
    logic [AW-1:0] m_src [NCH], m_dst [NCH], m_src0 [NCH], m_dst0 [NCH];
    logic [7:0]    m_size [NCH], m_cnt [NCH], m_cnt0 [NCH];
    logic [NCH-1:0] m_en = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr && got_n < 4096) begin
                got_a[got_n] = bus_addr;
                got_d[got_n] = bus_wdata;
                got_n++;
            end
            if ((bus_rd || bus_wr) && !busy) strobe_bad++;
            irq_seen |= irq;
            if (busy) busy_seen = 1'b1;
        end
    end

    task automatic chk(input string req, input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input int f, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 5'(ch); cfg_field = 3'(f); cfg_wdata = AW'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        case (f)
            0: m_mode[ch] = 8'(v);
            1: begin m_src[ch] = AW'(v); m_src0[ch] = AW'(v); end
            2: begin m_dst[ch] = AW'(v); m_dst0[ch] = AW'(v); end
            3: m_size[ch] = 8'(v);
            4: begin m_cnt[ch] = 8'(v); m_cnt0[ch] = 8'(v); end
            5: m_en[ch] = v[0];
            default: ;
        endcase
    endtask

    task automatic setup(input int ch, input int mode, input int s, input int d,
                         input int sz, input int cn);
        cfg(ch, 0, mode); cfg(ch, 1, s); cfg(ch, 2, d);
        cfg(ch, 3, sz); cfg(ch, 4, cn); cfg(ch, 5, 1);
    endtask

    // Model of one activation of channel c, following R2..R7.
    task automatic model_run(input int c0);
        int c = c0;
        forever begin
            logic rep, srep, drep, sstep, dstep;
            int n;
            rep = m_mode[c][0];
            srep = rep & m_mode[c][1];
            drep = rep & ~m_mode[c][1];
            sstep = srep | m_mode[c][2];
            dstep = drep | m_mode[c][3];
            n = (m_size[c] == 0) ? 256 : int'(m_size[c]);
            for (int b = 0; b < n; b++) begin
                exp_a[exp_n] = m_dst[c];
                exp_d[exp_n] = memf(m_src[c]);
                exp_n++;
                m_src[c] = m_src[c] + AW'(sstep);
                m_dst[c] = m_dst[c] + AW'(dstep);
            end
            if (m_cnt[c] == 8'd1) begin
                if (rep) begin
                    m_cnt[c] = m_cnt0[c];
                    if (srep) m_src[c] = m_src0[c];
                    if (drep) m_dst[c] = m_dst0[c];
                    if (m_mode[c][5]) exp_irq[c] = 1'b1;
                end else begin
                    m_cnt[c] = 8'd0;
                    m_en[c] = 1'b0;
                    exp_irq[c] = 1'b1;
                end
            end else begin
                m_cnt[c] = m_cnt[c] - 8'd1;
            end
            if (m_mode[c][4] && c != NCH - 1) c++;
            else break;
        end
    endtask

    // Pulse requests, wait until quiet, then compare writes and interrupts.
    task automatic fire(input logic [NCH-1:0] mask, input string req);
        logic [NCH-1:0] acc;
        int quiet = 0, guard = 0;
        logic ok;
        acc = mask & m_en;
        got_n = 0; exp_n = 0; irq_seen = '0; exp_irq = '0; busy_seen = 1'b0;
        for (int c = 0; c < NCH; c++) if (acc[c]) model_run(c);
        @(negedge clk);
        act_req = mask;
        @(negedge clk);
        act_req = '0;
        while (quiet < 4 && guard < 5000) begin
            @(negedge clk);
            guard++;
            quiet = busy ? 0 : quiet + 1;
        end
        ok = (got_n == exp_n);
        for (int i = 0; i < exp_n && ok; i++) begin
            if (got_a[i] !== exp_a[i] || got_d[i] !== exp_d[i]) begin
                ok = 1'b0;
                $display("FAIL %s byte %0d: actual %0h/%0h expected %0h/%0h",
                         req, i, got_a[i], got_d[i], exp_a[i], exp_d[i]);
            end
        end
        chk(req, ok, "write count/sequence", 32'(got_n), 32'(exp_n));
        chk(req, irq_seen == exp_irq, "irq set", 32'(irq_seen), 32'(exp_irq));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = 0; m_src[c] = 0; m_dst[c] = 0; m_src0[c] = 0;
            m_dst0[c] = 0; m_size[c] = 0; m_cnt[c] = 0; m_cnt0[c] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        chk("R1", !busy && !bus_rd && !bus_wr && irq == '0, "reset outputs",
            {busy, bus_rd, bus_wr, 1'b0}, 0);
        rst_n = 1'b1;
        fire(24'h000001, "R1 no channel enabled");

        // R2 R4 R5: normal mode, both sides step, count 2
        setup(3, 8'h0C, 16'h0100, 16'h0200, 4, 2);
        fire(24'h000008, "R2 R4 first activation");
        fire(24'h000008, "R5 expiry irq");
        fire(24'h000008, "R5 disabled request ignored");
        cfg(3, 4, 1); cfg(3, 5, 1);
        fire(24'h000008, "R5 re-armed");

        // R4: fixed source, stepping destination
        setup(5, 8'h08, 16'h0333, 16'h0400, 3, 5);
        fire(24'h000020, "R4 fixed source");
        fire(24'h000020, "R4 address kept across activations");

        // R3: size zero is 256 bytes
        setup(6, 8'h0C, 16'h1000, 16'h2000, 0, 3);
        fire(24'h000040, "R3 size 0 = 256 bytes");

        // R6: destination repeat, dst bit clear ignored, irq enabled
        setup(7, 8'h25, 16'h3000, 16'h3800, 2, 3);
        for (int k = 0; k < 4; k++) fire(24'h000080, "R6 dst repeat reload");
        // R6: source repeat, src bit clear ignored, irq disabled
        setup(4, 8'h0B, 16'h3100, 16'h3900, 3, 2);
        for (int k = 0; k < 3; k++) fire(24'h000010, "R6 src repeat no irq");

        // R7: chain 21 -> 22 -> 23, channel 23 chain bit set but not followed
        setup(21, 8'h1C, 16'h4000, 16'h4100, 2, 4);
        setup(22, 8'h1C, 16'h4200, 16'h4300, 3, 4);
        setup(23, 8'h1C, 16'h4400, 16'h4500, 1, 4);
        setup(0, 8'h0C, 16'h4600, 16'h4700, 1, 9);
        fire(24'h200000, "R7 chain stops at last channel");

        // R8: simultaneous requests served lowest first
        setup(2, 8'h0C, 16'h5000, 16'h5100, 2, 9);
        setup(9, 8'h0C, 16'h5200, 16'h5300, 2, 9);
        setup(12, 8'h04, 16'h5400, 16'h5500, 2, 9);
        fire(24'h001204, "R8 lowest first");

        // R10: count 0 runs 256 activations before expiry
        setup(1, 8'h0C, 16'h6000, 16'h6400, 1, 0);
        for (int k = 0; k < 256; k++) fire(24'h000002, "R10 count 0 = 256");
        fire(24'h000002, "R10 disabled after 256");

        // Random descriptors on channels 13..17, fired in random subsets
        for (int c = 13; c <= 17; c++)
            setup(c, ($urandom % 64) & ((c == 17) ? 8'h2F : 8'h3F),
                  $urandom % 65536, $urandom % 65536,
                  1 + $urandom % 6, 1 + $urandom % 4);
        for (int it = 0; it < 40; it++) begin
            int c = 13 + $urandom % 5;
            if ($urandom % 3 == 0)
                setup(c, ($urandom % 64) & ((c == 17) ? 8'h2F : 8'h3F),
                      $urandom % 65536, $urandom % 65536,
                      1 + $urandom % 6, 1 + $urandom % 4);
            else if (!m_en[c]) begin
                cfg(c, 4, 1 + $urandom % 4); cfg(c, 5, 1);
            end
            fire(NCH'(($urandom % 32) << 13), "R6 R7 R8 random");
        end

        // R9: no strobe while busy low, and busy was seen during a transfer
        fire(24'h000004, "R9 busy activation");
        chk("R9", busy_seen, "busy observed", 32'(busy_seen), 1);
        chk("R9", strobe_bad == 0, "strobes outside busy", 32'(strobe_bad), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule